// File: doc/BRIEF.md
# Futures Synchronization Cell

This block guards a single named value that may not exist yet. Consumers send read requests that carry a continuation identifier. If the value has already been written, the request is answered straight away on a dedicated response lane. If it has not, the identifier is parked in local pending storage. The first such parked request raises a one-cycle spawn request so that some producer can be started.

When the producer writes the value, every parked continuation is sent back out with the value. Pending storage is split into leaves, and each leaf drains on its own response lane, so several continuations leave in the same cycle. A request that arrives during this drain, or at any later time, is answered directly and is never parked. The value is written once. A later write is dropped and raises a sticky error flag.

All data streams use valid/ready. A request transfers on a cycle where `req_valid` and `req_ready` are both high. Each response lane transfers on a cycle where its `rsp_valid` and `rsp_ready` bits are both high. A lane that is valid holds its contents until it transfers. The producer write is a plain strobe and is always taken.

Top module: `future_cell`

## Requirements
- R1: After reset the value is absent, every `rsp_valid` bit is 0, `req_ready` is 1, `spawn_req` is 0 and `err_dup` is 0.
- R2: A request accepted while the value is present makes lane 0 valid on the next cycle. Lane 0 then carries the request's continuation in `rsp_cont[7:0]`, and `rsp_data` equals the stored value.
- R3: A request accepted while the value is absent produces no response on any lane until the value is written.
- R4: `spawn_req` is high for exactly one cycle, the cycle after the first request is accepted while the value is absent. It never rises again until reset.
- R5: The k-th parked request (counting from 0) is stored in leaf k mod 2, position k/2. Each leaf releases its entries in the order they arrived. Leaf i drives lane i+1, whose continuation is `rsp_cont[8*(i+1)+7 : 8*(i+1)]`.
- R6: From the cycle after the write, each leaf with entries left shows its oldest remaining entry on its lane together with the value. Each lane advances on its own `rsp_ready` bit, so up to two parked continuations leave per cycle. A released entry is freed.
- R7: While the value is absent and 8 continuations are parked, `req_ready` is 0.
- R8: While the value is absent and `wr_valid` is high, `req_ready` is 0. The write takes that cycle.
- R9: A request accepted while parked continuations are still draining is answered on lane 0 and is not parked.
- R10: A write while the value is present leaves the stored value unchanged and sets `err_dup`, which stays high until reset.
- R11: While the value is present and lane 0 is valid with `rsp_ready[0]` low, `req_ready` is 0 and lane 0 holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request ready |
| req_cont | input | 8 | Continuation identifier of the request |
| wr_valid | input | 1 | Producer write strobe |
| wr_data | input | 16 | Value written by the producer |
| rsp_valid | output | 3 | Per-lane response valid: lane 0 is the direct-answer lane, lanes 1 and 2 are the leaf release lanes |
| rsp_ready | input | 3 | Per-lane response ready |
| rsp_cont | output | 24 | Per-lane continuation identifier, 8 bits per lane, lane 0 in the low bits |
| rsp_data | output | 16 | Stored value, shared by all lanes |
| spawn_req | output | 1 | One-cycle request to start the producer |
| err_dup | output | 1 | Sticky flag for a write to an already present value |

## Verification
The bench builds the cell with its default values: 8-bit continuations, 16-bit data, and two leaves of four entries each. With only eight slots, the bench can fill storage completely, hold a ninth request against the full condition, and then collide it with the write. The drain then runs over just four entries per leaf, and the per-lane ready pattern lets the two lanes finish at different times, so ordering within each leaf and direct answers during the drain are both observed.

// File: rtl/fc_pkg.sv
package fc_pkg;
  // Round-robin placement of the k-th parked request across the leaves.
  function automatic int leaf_of(input int k, input int leaves);
    return k % leaves;
  endfunction

  function automatic int slot_of(input int k, input int leaves);
    return k / leaves;
  endfunction
endpackage

// File: rtl/fc_pend_leaf.sv
module fc_pend_leaf #(
  parameter int DEPTH  = 4,
  parameter int CONT_W = 8,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  logic [SLOT_W-1:0] ins_slot,
  input  logic [CONT_W-1:0] ins_cont,
  input  logic              rel_en,
  input  logic              pop,
  output logic              out_valid,
  output logic [CONT_W-1:0] out_cont
);
  logic [DEPTH-1:0]  vld_q;
  logic [CONT_W-1:0] mem_q [DEPTH];
  logic [SLOT_W-1:0] head;
  logic              any;

  // Oldest entry is the lowest occupied slot, since slots fill in ascending order.
  always_comb begin
    head = '0;
    any  = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i]) begin
        head = SLOT_W'(i);
        any  = 1'b1;
      end
    end
  end

  assign out_valid = rel_en && any;
  assign out_cont  = mem_q[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (ins_en) begin
        vld_q[ins_slot] <= 1'b1;
        mem_q[ins_slot] <= ins_cont;
      end
      if (out_valid && pop) vld_q[head] <= 1'b0;
    end
  end

  // R3
  no_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rel_en);

  // R5
  slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !vld_q[ins_slot]);

  // R6
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop) |=> (out_valid && $stable(out_cont)));
endmodule

// File: rtl/fc_hit_slot.sv
module fc_hit_slot #(
  parameter int CONT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CONT_W-1:0] load_cont,
  input  logic              ready,
  output logic              valid,
  output logic [CONT_W-1:0] cont
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      cont  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      cont  <= load_cont;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R11
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(cont)));
endmodule

// File: rtl/future_cell.sv
module future_cell #(
  parameter int CONT_W     = 8,
  parameter int DATA_W     = 16,
  parameter int LEAF_DEPTH = 4,
  parameter int NUM_LEAVES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [CONT_W-1:0]                req_cont,
  input  logic                             wr_valid,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_LEAVES:0]              rsp_valid,
  input  logic [NUM_LEAVES:0]              rsp_ready,
  output logic [(NUM_LEAVES+1)*CONT_W-1:0] rsp_cont,
  output logic [DATA_W-1:0]                rsp_data,
  output logic                             spawn_req,
  output logic                             err_dup
);
  localparam int CAP    = LEAF_DEPTH * NUM_LEAVES;
  localparam int CNT_W  = $clog2(CAP + 1);
  localparam int SLOT_W = $clog2(LEAF_DEPTH);

  logic              avail_q, spawned_q;
  logic [DATA_W-1:0] value_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              req_fire, hit_fire, miss_fire;
  int                ins_leaf;
  logic [SLOT_W-1:0] ins_slot;

  assign req_ready = avail_q ? (!rsp_valid[0] || rsp_ready[0])
                             : (!wr_valid && (cnt_q < CNT_W'(CAP)));
  assign req_fire  = req_valid && req_ready;
  assign hit_fire  = req_fire && avail_q;
  assign miss_fire = req_fire && !avail_q;
  assign rsp_data  = value_q;

  always_comb begin
    ins_leaf = fc_pkg::leaf_of(int'(cnt_q), NUM_LEAVES);
    ins_slot = SLOT_W'(fc_pkg::slot_of(int'(cnt_q), NUM_LEAVES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail_q   <= 1'b0;
      value_q   <= '0;
      cnt_q     <= '0;
      spawned_q <= 1'b0;
      spawn_req <= 1'b0;
      err_dup   <= 1'b0;
    end else begin
      spawn_req <= miss_fire && !spawned_q;
      if (miss_fire) begin
        cnt_q     <= cnt_q + 1'b1;
        spawned_q <= 1'b1;
      end
      if (wr_valid) begin
        if (avail_q) begin
          err_dup <= 1'b1;
        end else begin
          avail_q <= 1'b1;
          value_q <= wr_data;
          cnt_q   <= '0;
        end
      end
    end
  end

  fc_hit_slot #(.CONT_W(CONT_W)) hit_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hit_fire),
    .load_cont(req_cont),
    .ready    (rsp_ready[0]),
    .valid    (rsp_valid[0]),
    .cont     (rsp_cont[CONT_W-1:0])
  );

  for (genvar g = 0; g < NUM_LEAVES; g++) begin : g_leaf
    fc_pend_leaf #(.DEPTH(LEAF_DEPTH), .CONT_W(CONT_W)) leaf_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ins_en   (miss_fire && (ins_leaf == g)),
      .ins_slot (ins_slot),
      .ins_cont (req_cont),
      .rel_en   (avail_q),
      .pop      (rsp_ready[g+1]),
      .out_valid(rsp_valid[g+1]),
      .out_cont (rsp_cont[(g+1)*CONT_W +: CONT_W])
    );
  end

  // R4
  spawn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_req |=> !spawn_req);

  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail_q && cnt_q == CNT_W'(CAP)) |-> !req_ready);

  // R8
  write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail_q && wr_valid) |-> !req_ready);

  // R2
  hit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> (rsp_valid[0] && rsp_cont[CONT_W-1:0] == $past(req_cont)));

  // R3
  absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !avail_q |-> (rsp_valid == '0));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_dup |=> err_dup);

  // R10
  value_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && avail_q) |=> $stable(value_q));
endmodule

// File: tb/future_cell_tb.sv
module future_cell_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_cont = '0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rsp_valid;
  logic [2:0]  rsp_ready = '0;
  logic [23:0] rsp_cont;
  logic [15:0] rsp_data;
  logic        spawn_req;
  logic        err_dup;

  always #4 clk = ~clk;

  future_cell dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cont(req_cont), .wr_valid(wr_valid), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_cont(rsp_cont),
    .rsp_data(rsp_data), .spawn_req(spawn_req), .err_dup(err_dup)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  bit [31:0] lcg = 32'h1234_5678;

  // Behavioural reference state.
  bit     m_avail, m_err, m_spawned, m_spawn, m_hit_v;
  int     m_value, m_hit_c, m_cnt;
  int     lq0[$];
  int     lq1[$];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  function automatic bit exp_ready();
    if (m_avail) return !m_hit_v || rsp_ready[0];
    return !wr_valid && (m_cnt < 8);
  endfunction

  task automatic model_reset();
    m_avail = 0; m_err = 0; m_spawned = 0; m_spawn = 0; m_hit_v = 0;
    m_value = 0; m_hit_c = 0; m_cnt = 0;
    lq0.delete(); lq1.delete();
  endtask

  task automatic check_outputs();
    bit ev1, ev2, any;
    ev1 = m_avail && lq0.size() > 0;
    ev2 = m_avail && lq1.size() > 0;
    chk(req_ready === exp_ready(), "req_ready", int'(req_ready), int'(exp_ready()));
    chk(rsp_valid[0] === m_hit_v, "lane0 valid", int'(rsp_valid[0]), int'(m_hit_v));
    chk(rsp_valid[1] === ev1, "lane1 valid", int'(rsp_valid[1]), int'(ev1));
    chk(rsp_valid[2] === ev2, "lane2 valid", int'(rsp_valid[2]), int'(ev2));
    if (m_hit_v) chk(int'(rsp_cont[7:0]) == m_hit_c, "lane0 cont", int'(rsp_cont[7:0]), m_hit_c);
    if (ev1) chk(int'(rsp_cont[15:8]) == lq0[0], "lane1 cont", int'(rsp_cont[15:8]), lq0[0]);
    if (ev2) chk(int'(rsp_cont[23:16]) == lq1[0], "lane2 cont", int'(rsp_cont[23:16]), lq1[0]);
    any = m_hit_v || ev1 || ev2;
    if (any) chk(int'(rsp_data) == m_value, "rsp_data", int'(rsp_data), m_value);
    chk(spawn_req === m_spawn, "spawn_req", int'(spawn_req), int'(m_spawn));
    chk(err_dup === m_err, "err_dup", int'(err_dup), int'(m_err));
  endtask

  task automatic cycle();
    bit fire, pop0, pop1, pop2;
    #1;
    check_outputs();
    fire = req_valid && exp_ready();
    pop0 = m_hit_v && rsp_ready[0];
    pop1 = m_avail && lq0.size() > 0 && rsp_ready[1];
    pop2 = m_avail && lq1.size() > 0 && rsp_ready[2];
    @(posedge clk);
    if (pop0) m_hit_v = 0;
    if (pop1) void'(lq0.pop_front());
    if (pop2) void'(lq1.pop_front());
    m_spawn = 0;
    if (fire && m_avail) begin
      m_hit_v = 1; m_hit_c = int'(req_cont);
    end else if (fire) begin
      if (m_cnt % 2 == 0) lq0.push_back(int'(req_cont));
      else lq1.push_back(int'(req_cont));
      m_cnt++;
      m_spawn = !m_spawned;
      m_spawned = 1;
    end
    if (wr_valid) begin
      if (m_avail) m_err = 1;
      else begin m_avail = 1; m_value = int'(wr_data); end
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; wr_valid = 0; rsp_ready = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  function automatic logic [2:0] next_ready();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[18:16];
  endfunction

  initial begin
    do_reset();
    cur_req = "R1";
    repeat (2) cycle();

    // Park eight continuations; storage fills.
    cur_req = "R3 R4 R5";
    for (int k = 0; k < 8; k++) begin
      req_valid = 1; req_cont = 8'h10 + 8'(k); rsp_ready = next_ready();
      cycle();
    end
    cur_req = "R7";
    req_cont = 8'h99;
    repeat (3) cycle();
    // Write collides with a held request.
    cur_req = "R8";
    wr_valid = 1; wr_data = 16'hBEEF;
    cycle();
    wr_valid = 0;
    // Drain with a per-lane ready pattern and direct answers in between.
    cur_req = "R5 R6 R9";
    rsp_ready = 3'b011;
    cycle();
    for (int i = 0; i < 12; i++) begin
      req_valid = (i % 2 == 1); req_cont = 8'h40 + 8'(i);
      rsp_ready = next_ready() | 3'b001;
      cycle();
    end
    req_valid = 0; rsp_ready = 3'b111;
    repeat (3) cycle();
    // Duplicate write.
    cur_req = "R10";
    wr_valid = 1; wr_data = 16'h1234;
    cycle();
    wr_valid = 0;
    repeat (2) cycle();
    // Lane 0 back-pressure.
    cur_req = "R2 R11";
    rsp_ready = 3'b000; req_valid = 1; req_cont = 8'h55;
    repeat (4) cycle();
    rsp_ready = 3'b001;
    for (int i = 0; i < 4; i++) begin
      req_cont = 8'h60 + 8'(i);
      cycle();
    end
    req_valid = 0;
    repeat (2) cycle();

    // Value written before any request: no spawn, direct answers only.
    do_reset();
    cur_req = "R2 R4";
    cycle();
    wr_valid = 1; wr_data = 16'h0F0F;
    cycle();
    wr_valid = 0; req_valid = 1; rsp_ready = 3'b111;
    for (int i = 0; i < 4; i++) begin
      req_cont = 8'hA0 + 8'(i);
      cycle();
    end
    req_valid = 0;
    repeat (3) cycle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule